// File: doc/BRIEF.md
# Head-Per-Track Storage Transfer Sequencer

This block sequences word-by-word transfers between a host data channel and a head-per-track store held in on-chip word memory. The store is organised as tracks of 64-word sectors. A mode input selects one of two geometries: a disk layout with 90 sectors per track or a drum layout with 32 sectors per track. The host loads a 16-bit command word that holds a direction bit, a track and a sector. It starts the channel, and it then feeds or drains one word each time the data flag rises.

Rotational positioning is done outside the block. A separate position unit asserts a start strobe when the addressed sector passes under the heads. After that strobe the sequencer moves one word per word period. It steps the word pointer and, at the end of each sector, the sector and track fields of the command word. If the host stops a write partway through a sector, the sequencer fills the rest of that sector with zeros on its own.

Top module: `hpt_xfer_seq`

## Requirements
- R1: After a synchronous reset the following are all zero: the command word, the word pointer, the input and output buffers, the channel command, the data flag and the alignment flag. `busy` is low.
- R2: Command word bit 15 selects write (1) or read (0). In disk mode (`drumMode`=0) the track is in bits 13:7 and the sector in bits 6:0. In drum mode (`drumMode`=1) the track is in bits 14:5 and the sector in bits 4:0.
- R3: A word moves to or from store address (track × sectors-per-track + sector) × 64 + pointer. The sectors-per-track value is 90 for disk and 32 for drum.
- R4: After each word the pointer increments. At 64 the pointer returns to 0 and the sector increments. Past the last sector the sector returns to 0 and the track increments. Past track 127 (disk) or track 1023 (drum) the track returns to 0. The new fields are written back into the command word with bit 15 kept. A disk-mode write-back leaves bit 14 at zero.
- R5: `chStart` with the channel command clear sets the command, clears the pointer and clears `alignHit`. It also sets `dataFlag` on the next cycle when bit 15 is 1, and leaves `dataFlag` clear when bit 15 is 0.
- R6: After a `startStrobe` received while waiting, the first word moves WORD_PERIOD cycles later. Further words follow every WORD_PERIOD cycles while the command stays set, and each word sets `dataFlag`.
- R7: If the command is found clear at a word slot of a write and the pointer is not 0, the remaining words of the current sector are written as zeros.
- R8: A read from an address at or beyond MEM_DEPTH, or with a sector field at or above sectors-per-track, returns 0. A write to such an address leaves the store unchanged.
- R9: `chClear` clears the channel command and `dataFlag` on the next cycle. No further word moves after that.
- R10: `alignHit` rises when the start strobe is accepted. It is cleared by `chClear` or by an accepted `chStart`.
- R11: `flagClr` clears `dataFlag`. A word completing in the same cycle takes priority and leaves the flag set.
- R12: `chStart` while the channel command is already set has no effect: the pointer keeps its value and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drumMode | input | 1 | 0 selects disk geometry, 1 selects drum geometry |
| cwWrEn | input | 1 | Load the command word from `cwIn` |
| cwIn | input | 16 | New command word |
| cwOut | output | 16 | Current command word, including the automatic advance |
| chStart | input | 1 | Start the data channel |
| chClear | input | 1 | Clear the data channel command and flag |
| flagClr | input | 1 | Clear the data flag |
| startStrobe | input | 1 | Sector coincidence from the position unit |
| obufWrEn | input | 1 | Load the output buffer |
| obufIn | input | DATA_W | Word to write |
| ibufOut | output | DATA_W | Last word read |
| dataFlag | output | 1 | Channel flag: a word is wanted or available |
| chCmd | output | 1 | Channel command flip-flop |
| alignHit | output | 1 | Sector coincidence seen for this transfer |
| busy | output | 1 | Transfer, wait or zero fill in progress |

## Verification
The bench builds the block with MEM_DEPTH=4096 and WORD_PERIOD=4. With this store size the first 64 disk sectors fit, as do two drum tracks. Drum track 1 sector 0 then aliases disk track 0 sector 32, which lets one run check the two field layouts against each other through the shared store. Disk sector 70 falls past the end and would fold onto sector 6 if truncated, so a discarded write is visible. The short word period keeps full-sector runs, track wrap at 127 and 1023, and the zero-fill tail inside a brief run.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef struct packed {
    logic clrPtr;
    logic xferWord;
    logic fillWord;
  } hptStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_FILL
  } hptState_t;

endpackage

// File: rtl/hpt_ctrl.sv
module hpt_ctrl
  import hpt_pkg::*;
#(
  parameter int WORD_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       chStart,
  input  logic       chClear,
  input  logic       flagClr,
  input  logic       startStrobe,
  input  logic       cwWrite,
  input  logic       ptrZero,
  input  logic       ptrLast,
  output hptStrobe_t stb,
  output logic       chCmd,
  output logic       dataFlag,
  output logic       alignHit,
  output logic       busy
);

  localparam int TMR_W = (WORD_PERIOD > 1) ? $clog2(WORD_PERIOD) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WORD_PERIOD - 1);

  hptState_t state;
  logic [TMR_W-1:0] tmr;
  logic startGo;
  logic wordDue;

  always_comb begin
    startGo      = chStart && !chCmd && !chClear;
    wordDue      = (state == ST_RUN) && (tmr == TMR_LAST);
    stb          = '0;
    stb.clrPtr   = startGo;
    stb.xferWord = wordDue && chCmd && !chClear;
    stb.fillWord = (state == ST_FILL) && !startGo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else if (startGo) begin
      state <= ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: begin
          if (chClear)          state <= ST_IDLE;
          else if (startStrobe) state <= ST_RUN;
        end
        ST_RUN: begin
          if (wordDue && !stb.xferWord)
            state <= (cwWrite && !ptrZero) ? ST_FILL : ST_IDLE;
        end
        ST_FILL: begin
          if (ptrLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 tmr <= '0;
    else if (state == ST_WAIT && startStrobe) tmr <= '0;
    else if (state == ST_RUN)                tmr <= wordDue ? '0 : tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          chCmd <= 1'b0;
    else if (chClear) chCmd <= 1'b0;
    else if (startGo) chCmd <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                        dataFlag <= 1'b0;
    else if (chClear)                               dataFlag <= 1'b0;
    else if (stb.xferWord || (startGo && cwWrite))  dataFlag <= 1'b1;
    else if (flagClr)                               dataFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                                                alignHit <= 1'b0;
    else if (chClear || startGo)                            alignHit <= 1'b0;
    else if (state == ST_WAIT && startStrobe)               alignHit <= 1'b1;
  end

  assign busy = (state != ST_IDLE);

  assert_word_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    stb.xferWord |=> dataFlag);

  assert_clear_drops_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    chClear |=> (!chCmd && !dataFlag));

  assert_write_prime_R5: assert property (@(posedge clk) disable iff (rst)
    (chStart && !chCmd && !chClear && cwWrite) |=> (dataFlag && chCmd));

  assert_align_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    chClear |=> !alignHit);

endmodule

// File: rtl/hpt_dpath.sv
module hpt_dpath
  import hpt_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_SEC = 64,
  parameter int DISK_SECS     = 90,
  parameter int DRUM_SECS     = 32,
  parameter int MEM_DEPTH     = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drumMode,
  input  hptStrobe_t        stb,
  input  logic              cwWrEn,
  input  logic [15:0]       cwIn,
  input  logic              obufWrEn,
  input  logic [DATA_W-1:0] obufIn,
  output logic [15:0]       cwOut,
  output logic [DATA_W-1:0] ibufOut,
  output logic              cwWrite,
  output logic              ptrZero,
  output logic              ptrLast
);

  localparam int PTR_W  = $clog2(WORDS_PER_SEC);
  localparam int MEM_AW = $clog2(MEM_DEPTH);
  localparam int LIN_W  = 24;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WORDS_PER_SEC - 1);

  logic [15:0]       cwReg;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] obuf;
  logic [DATA_W-1:0] ibuf;
  logic [DATA_W-1:0] store [MEM_DEPTH];

  logic [9:0]       trk;
  logic [6:0]       sec;
  logic [6:0]       nsec;
  logic [9:0]       lastTrk;
  logic [7:0]       secInc;
  logic             secEnd;
  logic [6:0]       secNext;
  logic [9:0]       trkNext;
  logic [15:0]      cwAdv;
  logic [LIN_W-1:0] linAddr;
  logic [MEM_AW-1:0] memIdx;
  logic             addrOk;
  logic             doStore;

  always_comb begin
    trk     = drumMode ? cwReg[14:5] : {3'b000, cwReg[13:7]};
    sec     = drumMode ? {2'b00, cwReg[4:0]} : cwReg[6:0];
    nsec    = drumMode ? 7'(DRUM_SECS) : 7'(DISK_SECS);
    lastTrk = drumMode ? 10'd1023 : 10'd127;
    secInc  = {1'b0, sec} + 8'd1;
    secEnd  = (secInc >= {1'b0, nsec});
    secNext = secEnd ? 7'd0 : secInc[6:0];
    trkNext = secEnd ? ((trk == lastTrk) ? 10'd0 : trk + 10'd1) : trk;
    cwAdv   = drumMode ? {cwReg[15], trkNext, secNext[4:0]}
                       : {cwReg[15], 1'b0, trkNext[6:0], secNext};
    linAddr = (LIN_W'(trk) * LIN_W'(nsec) + LIN_W'(sec)) * LIN_W'(WORDS_PER_SEC)
              + LIN_W'(ptr);
    memIdx  = linAddr[MEM_AW-1:0];
    addrOk  = (sec < nsec) && (linAddr < LIN_W'(MEM_DEPTH));
    doStore = ((stb.xferWord && cwReg[15]) || stb.fillWord) && addrOk;
  end

  always_ff @(posedge clk) begin
    if (rst)                           cwReg <= '0;
    else if (cwWrEn)                   cwReg <= cwIn;
    else if (stb.xferWord && ptrLast)  cwReg <= cwAdv;
  end

  always_ff @(posedge clk) begin
    if (rst)                                ptr <= '0;
    else if (stb.clrPtr)                    ptr <= '0;
    else if (stb.xferWord || stb.fillWord)  ptr <= ptrLast ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           obuf <= '0;
    else if (obufWrEn) obuf <= obufIn;
  end

  always_ff @(posedge clk) begin
    if (rst)                               ibuf <= '0;
    else if (stb.xferWord && !cwReg[15])   ibuf <= addrOk ? store[memIdx] : '0;
  end

  always_ff @(posedge clk) begin
    if (doStore) store[memIdx] <= stb.fillWord ? '0 : obuf;
  end

  assign cwOut   = cwReg;
  assign ibufOut = ibuf;
  assign cwWrite = cwReg[15];
  assign ptrZero = (ptr == '0);
  assign ptrLast = (ptr == PTR_LAST);

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (stb.xferWord && ptr == PTR_LAST) |=> (ptr == '0));

  assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (stb.xferWord && !cwReg[15] && !addrOk) |=> (ibuf == '0));

endmodule

// File: rtl/hpt_xfer_seq.sv
module hpt_xfer_seq
  import hpt_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int WORDS_PER_SEC = 64,
  parameter int DISK_SECS     = 90,
  parameter int DRUM_SECS     = 32,
  parameter int MEM_DEPTH     = 4096,
  parameter int WORD_PERIOD   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drumMode,
  input  logic              cwWrEn,
  input  logic [15:0]       cwIn,
  output logic [15:0]       cwOut,
  input  logic              chStart,
  input  logic              chClear,
  input  logic              flagClr,
  input  logic              startStrobe,
  input  logic              obufWrEn,
  input  logic [DATA_W-1:0] obufIn,
  output logic [DATA_W-1:0] ibufOut,
  output logic              dataFlag,
  output logic              chCmd,
  output logic              alignHit,
  output logic              busy
);

  hptStrobe_t stb;
  logic cwWrite;
  logic ptrZero;
  logic ptrLast;

  hpt_ctrl #(.WORD_PERIOD(WORD_PERIOD)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .chStart     (chStart),
    .chClear     (chClear),
    .flagClr     (flagClr),
    .startStrobe (startStrobe),
    .cwWrite     (cwWrite),
    .ptrZero     (ptrZero),
    .ptrLast     (ptrLast),
    .stb         (stb),
    .chCmd       (chCmd),
    .dataFlag    (dataFlag),
    .alignHit    (alignHit),
    .busy        (busy)
  );

  hpt_dpath #(
    .DATA_W        (DATA_W),
    .WORDS_PER_SEC (WORDS_PER_SEC),
    .DISK_SECS     (DISK_SECS),
    .DRUM_SECS     (DRUM_SECS),
    .MEM_DEPTH     (MEM_DEPTH)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .drumMode (drumMode),
    .stb      (stb),
    .cwWrEn   (cwWrEn),
    .cwIn     (cwIn),
    .obufWrEn (obufWrEn),
    .obufIn   (obufIn),
    .cwOut    (cwOut),
    .ibufOut  (ibufOut),
    .cwWrite  (cwWrite),
    .ptrZero  (ptrZero),
    .ptrLast  (ptrLast)
  );

endmodule

// File: tb/hpt_xfer_seq_tb.sv
`timescale 1ns/1ps
module hpt_xfer_seq_tb;

  localparam int DEPTH  = 4096;
  localparam int PERIOD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drumMode = 1'b0, cwWrEn = 1'b0, chStart = 1'b0, chClear = 1'b0;
  logic flagClr = 1'b0, startStrobe = 1'b0, obufWrEn = 1'b0;
  logic [15:0] cwIn = '0, obufIn = '0;
  logic [15:0] cwOut, ibufOut;
  logic dataFlag, chCmd, alignHit, busy;

  always #2.5 clk = ~clk;

  hpt_xfer_seq #(.MEM_DEPTH(DEPTH), .WORD_PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst(rst), .drumMode(drumMode), .cwWrEn(cwWrEn), .cwIn(cwIn),
    .cwOut(cwOut), .chStart(chStart), .chClear(chClear), .flagClr(flagClr),
    .startStrobe(startStrobe), .obufWrEn(obufWrEn), .obufIn(obufIn),
    .ibufOut(ibufOut), .dataFlag(dataFlag), .chCmd(chCmd),
    .alignHit(alignHit), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  logic [15:0] refMem [DEPTH];
  logic [15:0] expQ [$];
  string tagQ [$];
  bit rdActive = 1'b0;
  bit prevFlag = 1'b0;
  logic [15:0] mCw;
  int mPtr;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // reference geometry model, written from the requirements
  function automatic int nsecOf(bit drum);
    return drum ? 32 : 90;
  endfunction
  function automatic int trkOf(bit drum, logic [15:0] c);
    return drum ? int'(c[14:5]) : int'(c[13:7]);
  endfunction
  function automatic int secOf(bit drum, logic [15:0] c);
    return drum ? int'(c[4:0]) : int'(c[6:0]);
  endfunction
  function automatic int linOf(bit drum, logic [15:0] c, int p);
    return (trkOf(drum, c) * nsecOf(drum) + secOf(drum, c)) * 64 + p;
  endfunction
  function automatic bit okOf(bit drum, logic [15:0] c, int p);
    return (secOf(drum, c) < nsecOf(drum)) && (linOf(drum, c, p) < DEPTH);
  endfunction
  function automatic logic [15:0] advOf(bit drum, logic [15:0] c);
    int t, s;
    t = trkOf(drum, c);
    s = secOf(drum, c) + 1;
    if (s >= nsecOf(drum)) begin
      s = 0;
      t = (t == (drum ? 1023 : 127)) ? 0 : t + 1;
    end
    if (drum) return {c[15], 10'(t), 5'(s)};
    return {c[15], 1'b0, 7'(t), 7'(s)};
  endfunction

  task automatic stepModel(bit drum);
    mPtr++;
    if (mPtr == 64) begin
      mPtr = 0;
      mCw  = advOf(drum, mCw);
    end
  endtask

  // monitor: pops one expected word per rising flag during a read
  always @(negedge clk) begin
    if (rdActive && dataFlag && !prevFlag) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected word got=%h exp=none", ibufOut);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, ibufOut, e);
      end
    end
    prevFlag = dataFlag;
  end

  task automatic waitFlag();
    while (dataFlag !== 1'b1) @(negedge clk);
  endtask
  task automatic waitIdle();
    while (busy !== 1'b0) @(negedge clk);
  endtask

  task automatic setCw(bit drum, logic [15:0] c);
    drumMode = drum; cwIn = c; cwWrEn = 1'b1;
    @(negedge clk); cwWrEn = 1'b0;
    mCw = c; mPtr = 0;
  endtask

  task automatic pulseStart();
    chStart = 1'b1; @(negedge clk); chStart = 1'b0;
  endtask
  task automatic pulseClear();
    chClear = 1'b1; @(negedge clk); chClear = 1'b0;
  endtask

  task automatic doWrite(bit drum, logic [15:0] c, int n, logic [15:0] seed);
    setCw(drum, c);
    pulseStart();
    chk("R5 write primes flag", dataFlag, 1);
    for (int i = 0; i < n; i++) begin
      automatic logic [15:0] w = seed + 16'(i);
      waitFlag();
      obufIn = w; obufWrEn = 1'b1; flagClr = 1'b1; startStrobe = (i == 0);
      @(negedge clk);
      obufWrEn = 1'b0; flagClr = 1'b0; startStrobe = 1'b0;
      if (okOf(drum, mCw, mPtr)) refMem[linOf(drum, mCw, mPtr)] = w;
      stepModel(drum);
    end
    waitFlag();
    pulseClear();
    waitIdle();
    if (mPtr != 0) begin
      for (int p = mPtr; p < 64; p++)
        if (okOf(drum, mCw, p)) refMem[linOf(drum, mCw, p)] = '0;
    end
    mPtr = 0;
    chk("R4 command word after write", cwOut, mCw);
  endtask

  task automatic doRead(bit drum, logic [15:0] c, int n, string tag);
    setCw(drum, c);
    pulseStart();
    chk("R5 read leaves flag clear", dataFlag, 0);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(okOf(drum, mCw, mPtr) ? refMem[linOf(drum, mCw, mPtr)] : 16'h0);
      tagQ.push_back(tag);
      stepModel(drum);
    end
    rdActive = 1'b1;
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    for (int i = 0; i < n; i++) begin
      waitFlag();
      flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    end
    pulseClear();
    waitIdle();
    rdActive = 1'b0;
    chk("R6 every read word delivered", expQ.size(), 0);
    chk("R4 command word after read", cwOut, mCw);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 cwOut", cwOut, 0);
    chk("R1 ibufOut", ibufOut, 0);
    chk("R1 dataFlag", dataFlag, 0);
    chk("R1 chCmd", chCmd, 0);
    chk("R1 alignHit", alignHit, 0);
    chk("R1 busy", busy, 0);

    // R2 R3 disk full sector write then read back
    doWrite(1'b0, 16'h8003, 64, 16'h1000);
    chk("R2 disk advance keeps write bit", cwOut, 16'h8004);
    doRead(1'b0, 16'h0003, 64, "R3 disk sector readback");

    // R7 drum write crossing into track 1, stopped partway, read via disk alias
    doWrite(1'b1, 16'h801F, 70, 16'h2000);
    chk("R4 drum sector wrap to next track", cwOut, 16'h8020);
    doRead(1'b0, 16'h0020, 64, "R7 zero fill seen through disk alias");

    // R8 write beyond store must not fold onto sector 6
    doWrite(1'b0, 16'h8006, 64, 16'h3000);
    doWrite(1'b0, 16'h8046, 64, 16'h4000);
    doRead(1'b0, 16'h0006, 64, "R8 out of range write discarded");
    doRead(1'b0, 16'h0046, 8, "R8 out of range read zero");
    // R8 invalid sector field
    setCw(1'b0, 16'h0064);
    doRead(1'b0, 16'h0064, 64, "R8 invalid sector read zero");
    chk("R4 invalid sector advances track", cwOut, 16'h0080);

    // R4 track wrap in both geometries
    doRead(1'b1, 16'h7FFF, 64, "R4 drum wrap data");
    chk("R4 drum track wrap", cwOut, 16'h0000);
    doWrite(1'b0, 16'hBFD9, 64, 16'h5000);
    chk("R4 disk track wrap keeps write bit", cwOut, 16'h8000);

    // R6 R10 R11 R12 R9 timing and control
    setCw(1'b0, 16'h0003);
    pulseStart();
    chk("R10 start clears alignHit", alignHit, 0);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    chk("R10 alignHit after strobe", alignHit, 1);
    repeat (PERIOD - 1) @(negedge clk);
    chk("R6 no word before period", dataFlag, 0);
    @(negedge clk);
    chk("R6 first word after period", dataFlag, 1);
    chk("R6 first word value", ibufOut, refMem[3 * 64]);
    flagClr = 1'b1; @(negedge clk); flagClr = 1'b0;
    chk("R11 flagClr clears flag", dataFlag, 0);
    pulseStart();
    chk("R12 start while active keeps alignHit", alignHit, 1);
    waitFlag();
    chk("R12 pointer not cleared", ibufOut, refMem[3 * 64 + 1]);
    pulseClear();
    chk("R9 command cleared", chCmd, 0);
    chk("R9 flag cleared", dataFlag, 0);
    chk("R10 clear drops alignHit", alignHit, 0);
    repeat (3 * PERIOD) @(negedge clk);
    chk("R9 no further word", dataFlag, 0);
    chk("R9 idle after clear", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule